// File: doc/BRIEF.md
# Line Code Violation Counter

This block counts line code violations on the receive side of a T1-style bipolar line. For each received bit it takes a bipolar-violation strobe, an indication that the bit arrived as a zero, and a flag that marks bits belonging to a recognised B8ZS substitution codeword. Two configuration inputs decide whether runs of zeros count as violations and whether B8ZS decoding is in force. The B8ZS setting also picks the run length that counts as excessive.

Events add into a running counter that saturates. A one-second tick copies the running total into a snapshot register and starts a new interval. Software can then read the snapshot as a high byte and a low byte at any time during the following second. The receive loss-of-sync flag is an input, but it does not stop counting.

Top module: `lcv_counter`

## Requirements
- R1: Reset sets both the running count and the snapshot to zero, so `snap_hi` and `snap_lo` read 0 after reset.
- R2: With `cfg_b8zs_en` low, every bit with `bit_en` and `bpv` high counts one event, whatever the value of `subst_cw`.
- R3: With `cfg_b8zs_en` high, a violation on a bit whose `subst_cw` is high is not counted.
- R4: With `cfg_xz_en` low, runs of zeros of any length add nothing to the count.
- R5: With `cfg_xz_en` high and `cfg_b8zs_en` low, a run of consecutive zero bits adds one event at the moment it reaches 16 bits. A longer run adds no further event, and a run of 15 adds nothing.
- R6: With `cfg_xz_en` high and `cfg_b8zs_en` high, the run threshold is 8 consecutive zero bits, again counted once per run.
- R7: A run ends only when a bit with `bit_en` high arrives with `rx_zero` low. Cycles with `bit_en` low leave the run length and the count untouched.
- R8: The running count stops at 65535 and never wraps.
- R9: On a cycle with `tick` high, the running count is copied to the snapshot. `snap_hi` carries bits 15..8 and `snap_lo` carries bits 7..0. The snapshot changes on no other cycle.
- R10: On the tick cycle the running count restarts, and an event in that same cycle is the first event of the new interval.
- R11: `rlos` has no effect on counting.
- R12: If a violation and a run reaching its threshold fall on the same bit, that bit counts two events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | A received bit is present this cycle |
| bpv | input | 1 | Bipolar violation on this bit |
| rx_zero | input | 1 | This bit arrived as a zero (no pulse) |
| subst_cw | input | 1 | This bit belongs to a recognised B8ZS codeword |
| cfg_xz_en | input | 1 | Count excessive-zero runs |
| cfg_b8zs_en | input | 1 | B8ZS decoding active (8-zero threshold, codeword exclusion) |
| rlos | input | 1 | Receive loss of sync (ignored for counting) |
| tick | input | 1 | One-second boundary strobe |
| snap_hi | output | 8 | Previous interval's count, high byte |
| snap_lo | output | 8 | Previous interval's count, low byte |

## Verification
The bench builds the block with its default parameters: a 16-bit count and zero-run thresholds of 16 and 8. With a 16-bit count, the saturation point of 65535 can be reached by driving about 66 thousand consecutive violations inside one interval, and this fits in the run. The two thresholds are short enough that random streams with a high share of zeros cross them often, in all four configuration combinations. Directed cases probe runs one bit short of each threshold and runs split by idle cycles.

// File: rtl/lcv_counter.sv
`timescale 1ns/1ps
module lcv_counter #(
  parameter int CNT_W      = 16,
  parameter int ZRUN_LONG  = 16,
  parameter int ZRUN_SHORT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_en,
  input  logic               bpv,
  input  logic               rx_zero,
  input  logic               subst_cw,
  input  logic               cfg_xz_en,
  input  logic               cfg_b8zs_en,
  input  logic               rlos,
  input  logic               tick,
  output logic [CNT_W/2-1:0] snap_hi,
  output logic [CNT_W/2-1:0] snap_lo
);
  localparam int RUN_W = $clog2(ZRUN_LONG + 1);
  localparam int HALF  = CNT_W / 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] acc, snap;
  logic [RUN_W-1:0] zrun, thr;
  logic             bpv_evt, xz_evt;
  logic [1:0]       inc;
  logic [CNT_W:0]   sum;

  assign thr     = cfg_b8zs_en ? RUN_W'(ZRUN_SHORT) : RUN_W'(ZRUN_LONG);
  assign bpv_evt = bit_en & bpv & ~(cfg_b8zs_en & subst_cw);
  assign xz_evt  = bit_en & cfg_xz_en & rx_zero & (zrun == thr - 1'b1);
  assign inc     = {1'b0, bpv_evt} + {1'b0, xz_evt};
  assign sum     = {1'b0, acc} + {{(CNT_W-1){1'b0}}, inc};

  always_ff @(posedge clk) begin
    if (!rst_n)
      zrun <= '0;
    else if (bit_en)
      zrun <= !rx_zero ? '0 : (zrun == RUN_W'(ZRUN_LONG)) ? zrun : zrun + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      snap <= '0;
    end else if (tick) begin
      snap <= acc;
      acc  <= {{(CNT_W-2){1'b0}}, inc};
    end else begin
      acc <= sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
    end
  end

  assign snap_hi = snap[CNT_W-1:HALF];
  assign snap_lo = snap[HALF-1:0];
endmodule

// File: rtl/lcv_counter_chk.sv
`timescale 1ns/1ps
module lcv_counter_chk #(
  parameter int CNT_W     = 16,
  parameter int ZRUN_LONG = 16,
  parameter int RUN_W     = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bit_en,
  input logic               bpv,
  input logic               rx_zero,
  input logic               subst_cw,
  input logic               cfg_xz_en,
  input logic               cfg_b8zs_en,
  input logic               rlos,
  input logic               tick,
  input logic [CNT_W-1:0]   acc,
  input logic [RUN_W-1:0]   zrun,
  input logic [CNT_W/2-1:0] snap_hi,
  input logic [CNT_W/2-1:0] snap_lo
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (acc == '0 && {snap_hi, snap_lo} == '0)); // R1
  AST_SUBST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && bpv && !rx_zero && subst_cw && cfg_b8zs_en && !tick) |=> $stable(acc)); // R3
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == MAXV && !tick) |=> acc == MAXV); // R8
  AST_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> acc >= $past(acc)); // R8
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable({snap_hi, snap_lo})); // R9
  AST_SNAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> {snap_hi, snap_lo} == $past(acc)); // R9
  AST_TICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !bit_en) |=> acc == '0); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(zrun)); // R7
  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    zrun <= RUN_W'(ZRUN_LONG)); // R5
  AST_SYNC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (rlos && bit_en && bpv && !rx_zero && !cfg_b8zs_en && !tick && acc != MAXV) |=> acc == $past(acc) + 1'b1); // R11
endmodule

bind lcv_counter lcv_counter_chk #(.CNT_W(CNT_W), .ZRUN_LONG(ZRUN_LONG), .RUN_W(RUN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bpv(bpv), .rx_zero(rx_zero),
  .subst_cw(subst_cw), .cfg_xz_en(cfg_xz_en), .cfg_b8zs_en(cfg_b8zs_en),
  .rlos(rlos), .tick(tick), .acc(acc), .zrun(zrun),
  .snap_hi(snap_hi), .snap_lo(snap_lo)
);

// File: tb/lcv_counter_tb.sv
`timescale 1ns/1ps
module lcv_counter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 0, bpv = 0, rx_zero = 0, subst_cw = 0;
  logic cfg_xz_en = 0, cfg_b8zs_en = 0, rlos = 0, tick = 0;
  logic [7:0] snap_hi, snap_lo;

  int n_chk = 0, n_fail = 0;
  int m_acc = 0, m_zrun = 0, m_snap = 0;

  always #2.5 clk = ~clk;

  lcv_counter u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bpv(bpv), .rx_zero(rx_zero),
    .subst_cw(subst_cw), .cfg_xz_en(cfg_xz_en), .cfg_b8zs_en(cfg_b8zs_en),
    .rlos(rlos), .tick(tick), .snap_hi(snap_hi), .snap_lo(snap_lo)
  );

  function automatic int ev_count(input logic be, bp, rz, sc, xz, b8, input int zr);
    int n = 0;
    int th = b8 ? 8 : 16;
    if (be && bp && !(b8 && sc)) n++;
    if (be && xz && rz && zr == th - 1) n++;
    return n;
  endfunction

  function automatic int run_next(input logic be, rz, input int zr);
    if (!be) return zr;
    if (!rz) return 0;
    return (zr >= 16) ? 16 : zr + 1;
  endfunction

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic step(input logic be, bp, rz, sc, tk, rl);
    int inc;
    @(negedge clk);
    bit_en = be; bpv = bp; rx_zero = rz; subst_cw = sc; tick = tk; rlos = rl;
    inc = ev_count(be, bp, rz, sc, cfg_xz_en, cfg_b8zs_en, m_zrun);
    m_zrun = run_next(be, rz, m_zrun);
    if (tk) begin
      m_snap = m_acc;
      m_acc = inc;
    end else begin
      m_acc = (m_acc + inc > 65535) ? 65535 : m_acc + inc;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic bits(input int n, input logic bp, rz, sc);
    for (int i = 0; i < n; i++) step(1'b1, bp, rz, sc, 1'b0, 1'b0);
  endtask

  task automatic tick_check(input string req, input int exp);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    check(req, {snap_hi, snap_lo}, exp);
    check({req, " model"}, {snap_hi, snap_lo}, m_snap);
  endtask

  task automatic set_cfg(input logic xz, b8);
    @(negedge clk);
    cfg_xz_en = xz; cfg_b8zs_en = b8;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h1bad5eed;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R1 reset", {snap_hi, snap_lo}, 0);
    tick_check("R1 empty interval", 0);

    set_cfg(0, 0);
    bits(3, 1, 0, 1); bits(2, 1, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0, 0);
    tick_check("R2", 5);

    set_cfg(0, 1);
    bits(2, 1, 0, 1); bits(3, 1, 0, 0);
    tick_check("R3", 3);

    set_cfg(0, 1);
    bits(30, 0, 1, 0);
    tick_check("R4", 0);

    set_cfg(1, 0);
    bits(1, 0, 0, 0); bits(15, 0, 1, 0); bits(1, 0, 0, 0);
    tick_check("R5 run of 15", 0);
    bits(40, 0, 1, 0); bits(1, 0, 0, 0);
    tick_check("R5 run of 40", 1);

    set_cfg(1, 1);
    bits(7, 0, 1, 0); bits(1, 0, 0, 0); bits(8, 0, 1, 0); bits(1, 0, 0, 0);
    bits(20, 0, 1, 0); bits(1, 0, 0, 0);
    tick_check("R6", 2);

    bits(4, 0, 1, 0);
    for (int i = 0; i < 5; i++) step(0, 1, 1, 0, 0, 0);
    bits(4, 0, 1, 0); bits(1, 0, 0, 0);
    tick_check("R7 idle inside run", 1);

    set_cfg(0, 0);
    bits(3, 1, 0, 0);
    step(1, 1, 0, 0, 1, 0);
    check("R10 tick snapshot", {snap_hi, snap_lo}, 3);
    tick_check("R10 tick event carried", 1);

    for (int i = 0; i < 6; i++) step(1, 1, 0, 0, 0, 1);
    tick_check("R11", 6);

    set_cfg(1, 0);
    bits(15, 0, 1, 0); bits(1, 1, 1, 0); bits(1, 0, 0, 0);
    tick_check("R12", 2);

    set_cfg(0, 0);
    bits(300, 1, 0, 0);
    tick_check("R9 word", 300);
    check("R9 high byte", snap_hi, 1);
    check("R9 low byte", snap_lo, 44);

    bits(65600, 1, 0, 0);
    tick_check("R8 saturation", 65535);
    check("R8 high byte", snap_hi, 255);
    tick_check("R8 restart after saturation", 0);

    for (int cfg = 0; cfg < 4; cfg++) begin
      set_cfg(cfg[0], cfg[1]);
      for (int k = 0; k < 6; k++) begin
        for (int c = 0; c < 300; c++) begin
          logic be, rz, bp, sc, rl;
          be = ($urandom % 10) < 8;
          rz = ($urandom % 10) < 9;
          bp = rz ? (($urandom % 50) == 0) : (($urandom % 4) == 0);
          sc = ($urandom % 5) == 0;
          rl = $urandom % 2;
          step(be, bp, rz, sc, 1'b0, rl);
        end
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R9 random interval", {snap_hi, snap_lo}, m_snap);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule